// File: doc/BRIEF.md
# APB4 Register File Slave

A compact APB4 completer that holds a fixed bank of data-width registers in three groups. Read-write registers are stored in the block and driven out to hardware. Read-only registers return values sampled from hardware inputs. Write-only registers produce a one-cycle pulse with the written data for hardware to act on. The block decodes the word address, commits writes in the first access cycle, and answers reads after a fixed latency.

Parameters set the size of each group and the data width. They also control whether an unmapped address raises PSLVERR and whether a wrong-direction access raises PSLVERR. Two optional flop stages can be added on the read path. One splits the read multiplexer. The other sits between the multiplexer and the bus response. Each stage adds one cycle to every read.

Top module: `apb_regfile`

## Requirements
- R1: Word index is paddr_i[ADDR_W-1:2] (32-bit data). Words 0..N_RW-1 are read-write, the next N_RO words are read-only, the next N_WO words are write-only, and every higher word is unmapped. The two low address bits are ignored.
- R2: A write to a read-write word updates byte b (bits 8b+7:8b) only when pstrb_i[b] is 1. The new value is visible on rw_q_o (register k at bits k*32+31:k*32) in the cycle after the access cycle.
- R3: A read of read-write word k returns its stored value. A read of read-only word j returns ro_d_i[j*32+31:j*32].
- R4: A write to write-only word k raises wo_pulse_o[k] for exactly the one cycle after the access cycle. In that cycle wo_data_o[k*32+31:k*32] holds the written data with disabled byte lanes forced to zero. A read of a write-only word returns zero.
- R5: A write to a read-only or unmapped word leaves every read-write register unchanged, and no other access changes them either.
- R6: With ERR_BAD_ADDR=1, an access to an unmapped word completes with pslverr_o=1. With ERR_BAD_ADDR=0, it completes with pslverr_o=0, and a read of it returns zero.
- R7: With ERR_BAD_DIR=1, a write to a read-only word or a read of a write-only word completes with pslverr_o=1. With ERR_BAD_DIR=0, it completes with pslverr_o=0. Correct-direction accesses to mapped words never set pslverr_o.
- R8: A write completes (pready_o=1) in its first access cycle. A read completes after exactly RETIME_FANIN+RETIME_RESP wait cycles.
- R9: pready_o is low outside the access phase, and pslverr_o is never high while pready_o is low.
- R10: ADDR_W is the larger of clog2(total bytes) and clog2(bytes per word)+1. ADDR_W_REQ replaces it only when ADDR_W_REQ is larger.
- R11: While rst_ni is low, all read-write registers are zero, all pulses are low and pready_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Completer select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | DATA_W | Write data |
| pstrb_i | input | DATA_W/8 | Byte lane enables for writes |
| prdata_o | output | DATA_W | Read data |
| pready_o | output | 1 | Transfer complete |
| pslverr_o | output | 1 | Transfer error |
| ro_d_i | input | N_RO*DATA_W | Hardware values for read-only words |
| rw_q_o | output | N_RW*DATA_W | Read-write register contents |
| wo_data_o | output | N_WO*DATA_W | Data of the last write to each write-only word |
| wo_pulse_o | output | N_WO | One-cycle write strobe per write-only word |

## Verification
The bench builds two instances with three read-write, two read-only and one write-only word. The first uses the defaults: both error options on, no read stages and a 5-bit address. It sweeps every word of its 8-word space, so the two unmapped words and both wrong directions produce errors with zero wait cycles. The second instance turns both error options off, adds both read stages and asks for a 6-bit address. It sweeps 16 words and reaches ten silent unmapped words and the 2-cycle read latency. Both instances also sweep all 16 strobe patterns on one read-write word and write a partial strobe to the write-only word.

// File: rtl/apb_regfile_pkg.sv
`timescale 1ns/1ps
package apb_regfile_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RW   = 2'd1,
    KIND_RO   = 2'd2,
    KIND_WO   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/apb_regfile_decode.sv
`timescale 1ns/1ps
module apb_regfile_decode
  import apb_regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LSB    = 2,
  parameter int N_RW   = 3,
  parameter int N_RO   = 2,
  parameter int N_WO   = 1,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  slot_o
);
  localparam int WORD_W = ADDR_W - LSB;
  localparam logic [WORD_W:0] RO_BASE = (WORD_W+1)'(N_RW);
  localparam logic [WORD_W:0] WO_BASE = (WORD_W+1)'(N_RW + N_RO);
  localparam logic [WORD_W:0] TOP_END = (WORD_W+1)'(N_RW + N_RO + N_WO);

  logic [WORD_W:0] word;
  assign word = {1'b0, addr_i[ADDR_W-1:LSB]};

  always_comb begin
    kind_o = KIND_NONE;
    slot_o = '0;
    if (word < RO_BASE) begin
      kind_o = KIND_RW;
      slot_o = IDX_W'(word);
    end else if (word < WO_BASE) begin
      kind_o = KIND_RO;
      slot_o = IDX_W'(word - RO_BASE);
    end else if (word < TOP_END) begin
      kind_o = KIND_WO;
      slot_o = IDX_W'(word - WO_BASE);
    end
  end
endmodule

// File: rtl/apb_regfile_store.sv
`timescale 1ns/1ps
module apb_regfile_store
  import apb_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_RW   = 3,
  parameter int N_WO   = 1,
  parameter int IDX_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  reg_kind_e              kind_i,
  input  logic [IDX_W-1:0]       slot_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [DATA_W/8-1:0]    strb_i,
  output logic [N_RW*DATA_W-1:0] rw_q_o,
  output logic [N_WO*DATA_W-1:0] wo_data_o,
  output logic [N_WO-1:0]        wo_pulse_o
);
  localparam int STRB_W = DATA_W / 8;

  for (genvar k = 0; k < N_RW; k++) begin : g_rw
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_i && (kind_i == KIND_RW) && (slot_i == IDX_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (hit) begin
        for (int b = 0; b < STRB_W; b++)
          if (strb_i[b]) q[8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
    assign rw_q_o[k*DATA_W +: DATA_W] = q;
  end

  for (genvar k = 0; k < N_WO; k++) begin : g_wo
    logic [DATA_W-1:0] d;
    logic              p;
    logic              hit;
    assign hit = wr_i && (kind_i == KIND_WO) && (slot_i == IDX_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d <= '0;
        p <= 1'b0;
      end else begin
        p <= hit;
        if (hit)
          for (int b = 0; b < STRB_W; b++)
            d[8*b +: 8] <= strb_i[b] ? wdata_i[8*b +: 8] : 8'h00;
      end
    end
    assign wo_data_o[k*DATA_W +: DATA_W] = d;
    assign wo_pulse_o[k] = p;
  end
endmodule

// File: rtl/apb_regfile_rdpath.sv
`timescale 1ns/1ps
module apb_regfile_rdpath
  import apb_regfile_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int N_RW         = 3,
  parameter int N_RO         = 2,
  parameter int IDX_W        = 3,
  parameter bit RETIME_FANIN = 1'b0,
  parameter bit RETIME_RESP  = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  reg_kind_e              kind_i,
  input  logic [IDX_W-1:0]       slot_i,
  input  logic [N_RW*DATA_W-1:0] rw_q_i,
  input  logic [N_RO*DATA_W-1:0] ro_d_i,
  output logic [DATA_W-1:0]      rdata_o
);
  logic [DATA_W-1:0] rw_val, ro_val, rw_grp, ro_grp, merged;

  always_comb begin
    rw_val = '0;
    for (int k = 0; k < N_RW; k++)
      if (kind_i == KIND_RW && slot_i == IDX_W'(k)) rw_val = rw_q_i[k*DATA_W +: DATA_W];
  end

  always_comb begin
    ro_val = '0;
    for (int k = 0; k < N_RO; k++)
      if (kind_i == KIND_RO && slot_i == IDX_W'(k)) ro_val = ro_d_i[k*DATA_W +: DATA_W];
  end

  // optional cut between per-group selection and final merge
  if (RETIME_FANIN) begin : g_fanin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rw_grp <= '0;
        ro_grp <= '0;
      end else begin
        rw_grp <= rw_val;
        ro_grp <= ro_val;
      end
    end
  end else begin : g_no_fanin
    assign rw_grp = rw_val;
    assign ro_grp = ro_val;
  end

  assign merged = rw_grp | ro_grp;

  if (RETIME_RESP) begin : g_resp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o <= '0;
      else         rdata_o <= merged;
    end
  end else begin : g_no_resp
    assign rdata_o = merged;
  end
endmodule

// File: rtl/apb_regfile.sv
`timescale 1ns/1ps
module apb_regfile
  import apb_regfile_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int N_RW         = 3,
  parameter int N_RO         = 2,
  parameter int N_WO         = 1,
  parameter bit ERR_BAD_ADDR = 1'b1,
  parameter bit ERR_BAD_DIR  = 1'b1,
  parameter bit RETIME_FANIN = 1'b0,
  parameter bit RETIME_RESP  = 1'b0,
  parameter int ADDR_W_REQ   = 0,
  localparam int STRB_W      = DATA_W / 8,
  localparam int LSB         = $clog2(STRB_W),
  localparam int N_REG       = N_RW + N_RO + N_WO,
  localparam int SPAN_W      = $clog2(N_REG * STRB_W),
  localparam int MIN_AW      = (SPAN_W > LSB + 1) ? SPAN_W : LSB + 1,
  localparam int ADDR_W      = (ADDR_W_REQ > MIN_AW) ? ADDR_W_REQ : MIN_AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   psel_i,
  input  logic                   penable_i,
  input  logic                   pwrite_i,
  input  logic [ADDR_W-1:0]      paddr_i,
  input  logic [DATA_W-1:0]      pwdata_i,
  input  logic [STRB_W-1:0]      pstrb_i,
  output logic [DATA_W-1:0]      prdata_o,
  output logic                   pready_o,
  output logic                   pslverr_o,
  input  logic [N_RO*DATA_W-1:0] ro_d_i,
  output logic [N_RW*DATA_W-1:0] rw_q_o,
  output logic [N_WO*DATA_W-1:0] wo_data_o,
  output logic [N_WO-1:0]        wo_pulse_o
);
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;
  localparam int LAT   = int'(RETIME_FANIN) + int'(RETIME_RESP);

  reg_kind_e        kind;
  logic [IDX_W-1:0] slot;
  logic             access, wr_en, bad_dir, err;
  logic [1:0]       wait_cnt;

  apb_regfile_decode #(
    .ADDR_W(ADDR_W), .LSB(LSB), .N_RW(N_RW), .N_RO(N_RO), .N_WO(N_WO), .IDX_W(IDX_W)
  ) u_decode (
    .addr_i(paddr_i), .kind_o(kind), .slot_o(slot)
  );

  assign access = psel_i && penable_i;
  assign wr_en  = access && pwrite_i;

  apb_regfile_store #(
    .DATA_W(DATA_W), .N_RW(N_RW), .N_WO(N_WO), .IDX_W(IDX_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_en), .kind_i(kind), .slot_i(slot),
    .wdata_i(pwdata_i), .strb_i(pstrb_i), .rw_q_o(rw_q_o),
    .wo_data_o(wo_data_o), .wo_pulse_o(wo_pulse_o)
  );

  apb_regfile_rdpath #(
    .DATA_W(DATA_W), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W),
    .RETIME_FANIN(RETIME_FANIN), .RETIME_RESP(RETIME_RESP)
  ) u_rdpath (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind), .slot_i(slot),
    .rw_q_i(rw_q_o), .ro_d_i(ro_d_i), .rdata_o(prdata_o)
  );

  // read wait counter: runs through the access phase until the pipeline has filled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            wait_cnt <= '0;
    else if (access && !pwrite_i && !pready_o) wait_cnt <= wait_cnt + 2'd1;
    else                                    wait_cnt <= '0;
  end

  assign pready_o = access && (pwrite_i || wait_cnt == 2'(LAT));

  assign bad_dir   = (pwrite_i && kind == KIND_RO) || (!pwrite_i && kind == KIND_WO);
  assign err       = (ERR_BAD_ADDR && kind == KIND_NONE) || (ERR_BAD_DIR && bad_dir);
  assign pslverr_o = pready_o && err;
endmodule

// File: rtl/apb_regfile_chk.sv
`timescale 1ns/1ps
module apb_regfile_chk #(
  parameter int DATA_W       = 32,
  parameter int N_RW         = 3,
  parameter int N_RO         = 2,
  parameter int N_WO         = 1,
  parameter bit RETIME_FANIN = 1'b0,
  parameter bit RETIME_RESP  = 1'b0,
  parameter int ADDR_W       = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   psel_i,
  input logic                   penable_i,
  input logic                   pwrite_i,
  input logic [ADDR_W-1:0]      paddr_i,
  input logic [DATA_W-1:0]      pwdata_i,
  input logic [DATA_W/8-1:0]    pstrb_i,
  input logic                   pready_o,
  input logic                   pslverr_o,
  input logic [N_RW*DATA_W-1:0] rw_q_o,
  input logic [N_WO-1:0]        wo_pulse_o
);
  localparam int LSB    = $clog2(DATA_W / 8);
  localparam int WORD_W = ADDR_W - LSB;
  localparam int LAT    = int'(RETIME_FANIN) + int'(RETIME_RESP);

  logic             acc;
  logic [WORD_W-1:0] word;
  assign acc  = psel_i && penable_i;
  assign word = paddr_i[ADDR_W-1:LSB];

  assert_err_only_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> pready_o);

  assert_idle_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> !pready_o);

  assert_write_no_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pwrite_i) |-> pready_o);

  if (LAT > 0) begin : g_lat
    assert_read_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && !pwrite_i && !$past(acc)) |-> !pready_o);
  end

  assert_rw_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && pwrite_i) |=> $stable(rw_q_o));

  for (genvar k = 0; k < N_RW; k++) begin : g_rw
    assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && pwrite_i && word == WORD_W'(k) && (&pstrb_i))
        |=> rw_q_o[k*DATA_W +: DATA_W] == $past(pwdata_i));
  end

  for (genvar k = 0; k < N_WO; k++) begin : g_wo
    assert_pulse_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wo_pulse_o[k] |-> $past(acc && pwrite_i && word == WORD_W'(N_RW + N_RO + k)));
  end
endmodule

bind apb_regfile apb_regfile_chk #(
  .DATA_W(DATA_W), .N_RW(N_RW), .N_RO(N_RO), .N_WO(N_WO),
  .RETIME_FANIN(RETIME_FANIN), .RETIME_RESP(RETIME_RESP), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
  .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i), .pstrb_i(pstrb_i),
  .pready_o(pready_o), .pslverr_o(pslverr_o), .rw_q_o(rw_q_o), .wo_pulse_o(wo_pulse_o)
);

// File: tb/apb_regfile_tb.sv
`timescale 1ns/1ps
module apb_regfile_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, sel_a, sel_b, penable, pwrite;
  logic [5:0]  paddr;
  logic [31:0] pwdata;
  logic [3:0]  pstrb;
  logic [63:0] ro_d;
  logic [31:0] rd_a, rd_b, wod_a, wod_b;
  logic        rdy_a, rdy_b, err_a, err_b;
  logic [95:0] rwq_a, rwq_b;
  logic [0:0]  pl_a, pl_b;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [2][3];

  apb_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(sel_a), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr[4:0]), .pwdata_i(pwdata), .pstrb_i(pstrb), .prdata_o(rd_a),
    .pready_o(rdy_a), .pslverr_o(err_a), .ro_d_i(ro_d), .rw_q_o(rwq_a),
    .wo_data_o(wod_a), .wo_pulse_o(pl_a)
  );

  apb_regfile #(
    .ERR_BAD_ADDR(1'b0), .ERR_BAD_DIR(1'b0), .RETIME_FANIN(1'b1), .RETIME_RESP(1'b1),
    .ADDR_W_REQ(6)
  ) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(sel_b), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .pstrb_i(pstrb), .prdata_o(rd_b),
    .pready_o(rdy_b), .pslverr_o(err_b), .ro_d_i(ro_d), .rw_q_o(rwq_b),
    .wo_data_o(wod_b), .wo_pulse_o(pl_b)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] s);
    for (int b = 0; b < 4; b++) lane_mask[8*b +: 8] = s[b] ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [31:0] rw_of(input bit b, input int k);
    return b ? rwq_b[k*32 +: 32] : rwq_a[k*32 +: 32];
  endfunction

  task automatic xfer(input bit b, input bit wr, input logic [5:0] a, input logic [31:0] wd,
                      input logic [3:0] st, output logic [31:0] rd, output logic er,
                      output int waits, output logic pl, output logic [31:0] wod);
    @(negedge clk);
    sel_a = !b; sel_b = b; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd; pstrb = st;
    @(negedge clk);
    penable = 1'b1;
    waits = 0;
    #1;
    while (!(b ? rdy_b : rdy_a) && waits < 8) begin
      if (b ? err_b : err_a) begin
        checks++; failures++;
        $display("FAIL R9 pslverr while not ready act=1 exp=0");
      end
      waits++;
      @(negedge clk);
      #1;
    end
    rd = b ? rd_b : rd_a;
    er = b ? err_b : err_a;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0;
    #1;
    pl  = b ? pl_b[0] : pl_a[0];
    wod = b ? wod_b : wod_a;
  endtask

  task automatic run_suite(input bit b);
    int nwords = b ? 16 : 8;
    int lat    = b ? 2 : 0;
    bit errs   = !b;
    logic [31:0] rd, wod, wd, expd;
    logic er, pl;
    int waits;
    // write sweep over the whole decoded space; low address bits vary (R1)
    for (int w = 0; w < nwords; w++) begin
      wd = (32'h1111_1111 * (w + 1)) ^ 32'h8000_0000;
      xfer(b, 1'b1, 6'(w * 4 + w % 4), wd, 4'hF, rd, er, waits, pl, wod);
      chk($sformatf("R6/R7 write err word %0d", w), 32'(er),
          32'(errs && (w >= 6 || (w >= 3 && w < 5))));
      chk("R8 write waits", 32'(waits), 32'd0);
      if (w < 3) model[b][w] = wd;
      for (int k = 0; k < 3; k++)
        chk($sformatf("R2/R5 rw reg %0d after write word %0d", k, w), rw_of(b, k), model[b][k]);
      chk($sformatf("R4 pulse after write word %0d", w), 32'(pl), 32'(w == 5));
      if (w == 5) chk("R4 wo data full strobe", wod, wd);
    end
    // read sweep (R1, R3, R4, R6, R7, R8)
    for (int w = 0; w < nwords; w++) begin
      xfer(b, 1'b0, 6'(w * 4 + (3 - w % 4)), 32'h0, 4'h0, rd, er, waits, pl, wod);
      if (w < 3)      expd = model[b][w];
      else if (w < 5) expd = ro_d[(w - 3) * 32 +: 32];
      else            expd = 32'h0;
      chk($sformatf("R3 read data word %0d", w), rd, expd);
      chk($sformatf("R6/R7 read err word %0d", w), 32'(er), 32'(errs && w >= 5));
      chk($sformatf("R8 read waits word %0d", w), 32'(waits), 32'(lat));
    end
    // every strobe pattern on read-write word 1 (R2)
    for (int s = 0; s < 16; s++) begin
      wd = 32'h89AB_CDEF ^ {8{4'(s)}};
      xfer(b, 1'b1, 6'd4, wd, 4'(s), rd, er, waits, pl, wod);
      model[b][1] = (model[b][1] & ~lane_mask(4'(s))) | (wd & lane_mask(4'(s)));
      chk($sformatf("R2 strobe %0d", s), rw_of(b, 1), model[b][1]);
      chk("R5 word 0 untouched", rw_of(b, 0), model[b][0]);
    end
    // partial strobe on write-only word (R4)
    xfer(b, 1'b1, 6'd20, 32'hDEAD_BEEF, 4'b0110, rd, er, waits, pl, wod);
    chk("R4 pulse partial", 32'(pl), 32'd1);
    chk("R4 wo data masked", wod, 32'h00AD_BE00);
    @(negedge clk); #1;
    chk("R4 pulse one cycle", 32'(b ? pl_b[0] : pl_a[0]), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pstrb = '0;
    ro_d = {32'hFACE_0001, 32'hFACE_0000};
    for (int i = 0; i < 2; i++) for (int k = 0; k < 3; k++) model[i][k] = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 rw regs reset a", rwq_a[31:0] | rwq_a[63:32] | rwq_a[95:64], 32'h0);
    chk("R11 rw regs reset b", rwq_b[31:0] | rwq_b[63:32] | rwq_b[95:64], 32'h0);
    chk("R11 pulses reset", 32'({pl_a, pl_b}), 32'd0);
    chk("R11 ready low in reset", 32'({rdy_a, rdy_b}), 32'd0);
    rst_n = 1'b1;
    chk("R10 default address width", 32'($bits(u_dut.paddr_i)), 32'd5);
    chk("R10 requested address width", 32'($bits(u_dut_alt.paddr_i)), 32'd6);
    run_suite(1'b0);
    run_suite(1'b1);
    summary();
    $finish;
  end
endmodule